// File: doc/BRIEF.md
# Load and Stack Bus Cycle Sequencer

This block paces the bus activity of an 8-bit processor core through its load and stack instructions. It advances one T-state per clock. Opcode and operand bytes arrive on a plain combinational read port. The block classifies each instruction, including forms reached through the index prefixes (0xDD, 0xFD) and the extended prefix (0xED). For that instruction it plays out the matching mix of opcode fetches, memory reads, memory writes and internal delay cycles, each at its own length.

On every clock the block reports the following:
- the type of the current machine cycle and the T-state index within it;
- whether the read in progress is fetching an instruction byte (an immediate, a displacement or half of an address);
- the bus address, taken from the program counter, from the latched direct address or from the stack pointer. Accesses through a register pointer drive zero, since the register file sits outside this block.

The block also owns the stack pointer and adjusts it on push and pop. It raises a one-cycle pulse when an instruction completes, and it keeps a sticky flag for an unknown opcode that follows a prefix.

Top module: `ld_cycle_seq`

## Requirements
- R1: Reset state: cycle type fetch (cycType 00), tState 0, memAddr at the program-counter reset value, spVal at the stack-pointer reset value, instDone and illegal low. The cycle-type encoding is 00 fetch, 01 read, 10 write, 11 internal.
- R2: Each of the following is a single 4-T fetch with no further cycle: an unprefixed 01dddsss with neither field 110, the code 0x76, and any unprefixed code outside the load and stack set. After 0xDD or 0xFD, a 01dddsss code with neither field 110 is two 4-T fetches.
- R3: The following pointer and immediate loads run these cycles:
  - 01ddd110, 0x0A and 0x1A: F4 then R3.
  - 01110sss, 0x02 and 0x12: F4 then W3.
  - 00ddd110 (except 0x36): F4 then an operand read of 3.
  - 0x36: F4, operand read, W3.
  - memAddr is zero during each pointer data access.
- R4: A 0xDD or 0xFD prefix costs one leading 4-T fetch, and a prefix may follow a prefix. The indexed forms then run as follows:
  - Indexed register-to-memory load: F4 F4, displacement read, internal 5-T, then R3 or W3 (19 T).
  - Indexed immediate store (0x36): F4 F4, displacement read, data read, internal 2-T, W3 (19 T).
- R5: 0x32 and 0x3A read the low then the high address byte, then make one 3-T access at address {high, low} (13 T).
- R6: 0x22 and 0x2A make two accesses at the direct address and then the address plus one (16 T). With a 0xDD or 0xFD prefix, and for 0xED 01pp0011 and 0xED 01pp1011, these take 20 T. 00pp0001 is F4 plus two operand reads; with a prefix, 0x21 is F4 F4 plus two operand reads.
- R7: 0xF9 is a single stretched 6-T fetch. With a 0xDD or 0xFD prefix it is F4 then F6.
- R8: 11pp0101 runs a 5-T fetch, then writes at SP-1, then at SP-2. spVal drops by 2 at the end of the fetch.
- R9: 11pp0001 runs F4, then reads at SP and SP+1. spVal rises by 2 once the instruction completes.
- R10: operandCyc is high exactly during reads of instruction bytes after the opcode, and only in read cycles. memAddr then carries successive program-counter values.
- R11: instDone pulses on the last T-state of the final cycle. The next clock begins a fetch at tState 0, addressed at the byte after the instruction.
- R12: An opcode after 0xED other than 01pp0011 or 01pp1011, or an opcode after 0xDD/0xFD outside the indexed load set, runs as a 4-T fetch only. It sets illegal, which stays set until reset.
- R13: tState counts from 0 up to the cycle length minus one and restarts at 0 for each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| memData | input | 8 | Byte at memAddr from the read port |
| memAddr | output | ADDR_W | Bus address for the current cycle |
| cycType | output | 2 | Current machine-cycle type |
| tState | output | 3 | T-state index within the cycle |
| operandCyc | output | 1 | Current read fetches an instruction byte |
| instDone | output | 1 | Last T-state of the instruction |
| illegal | output | 1 | Sticky unknown-prefixed-opcode flag |
| spVal | output | ADDR_W | Stack pointer |

## Verification
The bench builds the block with a 16-bit address, a program counter starting at 0x0000 and the stack pointer at 0x8000. It serves instruction bytes from a 256-byte window, so the program, the direct addresses and the stack traffic stay easy to predict. The bench sweeps every 01dddsss code and compares the observed cycle-type and length signature against one derived from the two register fields. It then walks each prefixed, direct, immediate and stack form, checking data addresses, stack-pointer movement and program-counter continuity, and ends with the illegal-prefix cases to show the flag persists.

// File: rtl/ld_cycle_seq_pkg.sv
package ld_cycle_seq_pkg;

  localparam int T_W = 3;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_INT   = 2'b11
  } cyc_e;

  typedef enum logic [2:0] {
    AS_PC, AS_PTR, AS_DIR0, AS_DIR1, AS_STKLO, AS_STKHI
  } addr_e;

  typedef enum logic [3:0] {
    SH_NONE, SH_RD1, SH_WR1, SH_IMM8, SH_MEMIMM, SH_IDXRD, SH_IDXWR, SH_IDXIMM,
    SH_DIRRD1, SH_DIRWR1, SH_DIRRD2, SH_DIRWR2, SH_IMM16, SH_SPLD, SH_PUSH, SH_POP
  } shape_e;

  typedef enum logic [1:0] {PFX_NONE, PFX_IDX, PFX_EXT} pfx_e;

  typedef struct packed {
    cyc_e           cyc;
    logic [T_W-1:0] len;
    logic           opnd;
    logic           last;
    addr_e          addr;
  } step_t;

  typedef struct packed {
    shape_e         shape;
    logic           isPfx;
    pfx_e           nextPfx;
    logic           bad;
    logic [T_W-1:0] fetchLen;
  } dec_t;

  typedef struct packed {
    logic  latchOp;
    logic  pcInc;
    logic  latchOpnd;
    logic  spDec2;
    logic  spInc2;
    addr_e addrSel;
  } strobe_t;

  function automatic step_t mk(input cyc_e c, input logic [T_W-1:0] l,
                               input logic o, input logic la, input addr_e a);
    mk = '{cyc: c, len: l, opnd: o, last: la, addr: a};
  endfunction

  // Cycles that follow the final opcode fetch, indexed by step.
  function automatic step_t seqStep(input shape_e sh, input logic [T_W-1:0] st);
    step_t s;
    s = mk(CYC_INT, 3'd1, 1'b0, 1'b1, AS_PC);
    case (sh)
      SH_RD1:    s = mk(CYC_READ, 3'd3, 1'b0, 1'b1, AS_PTR);
      SH_WR1:    s = mk(CYC_WRITE, 3'd3, 1'b0, 1'b1, AS_PTR);
      SH_IMM8:   s = mk(CYC_READ, 3'd3, 1'b1, 1'b1, AS_PC);
      SH_MEMIMM: s = (st == 0) ? mk(CYC_READ, 3'd3, 1'b1, 1'b0, AS_PC)
                               : mk(CYC_WRITE, 3'd3, 1'b0, 1'b1, AS_PTR);
      SH_IDXRD, SH_IDXWR: begin
        case (st)
          3'd0:    s = mk(CYC_READ, 3'd3, 1'b1, 1'b0, AS_PC);
          3'd1:    s = mk(CYC_INT, 3'd5, 1'b0, 1'b0, AS_PC);
          default: s = mk((sh == SH_IDXRD) ? CYC_READ : CYC_WRITE, 3'd3, 1'b0, 1'b1, AS_PTR);
        endcase
      end
      SH_IDXIMM: begin
        case (st)
          3'd0, 3'd1: s = mk(CYC_READ, 3'd3, 1'b1, 1'b0, AS_PC);
          3'd2:       s = mk(CYC_INT, 3'd2, 1'b0, 1'b0, AS_PC);
          default:    s = mk(CYC_WRITE, 3'd3, 1'b0, 1'b1, AS_PTR);
        endcase
      end
      SH_DIRRD1, SH_DIRWR1, SH_DIRRD2, SH_DIRWR2: begin
        if (st < 3'd2)
          s = mk(CYC_READ, 3'd3, 1'b1, 1'b0, AS_PC);
        else
          s = mk((sh == SH_DIRRD1 || sh == SH_DIRRD2) ? CYC_READ : CYC_WRITE, 3'd3, 1'b0,
                 (st == 3'd3) || sh == SH_DIRRD1 || sh == SH_DIRWR1,
                 (st == 3'd3) ? AS_DIR1 : AS_DIR0);
      end
      SH_IMM16:  s = mk(CYC_READ, 3'd3, 1'b1, st == 3'd1, AS_PC);
      SH_PUSH:   s = mk(CYC_WRITE, 3'd3, 1'b0, st == 3'd1, (st == 0) ? AS_STKHI : AS_STKLO);
      SH_POP:    s = mk(CYC_READ, 3'd3, 1'b0, st == 3'd1, (st == 0) ? AS_STKLO : AS_STKHI);
      default:   s = mk(CYC_INT, 3'd1, 1'b0, 1'b1, AS_PC);
    endcase
    return s;
  endfunction

  function automatic logic hasSteps(input shape_e sh);
    return sh != SH_NONE && sh != SH_SPLD;
  endfunction

  function automatic dec_t decode(input pfx_e pfx, input logic [7:0] op);
    dec_t d;
    d = '{shape: SH_NONE, isPfx: 1'b0, nextPfx: PFX_NONE, bad: 1'b0, fetchLen: 3'd4};
    if (pfx == PFX_EXT) begin
      if (op[7:6] == 2'b01 && op[2:0] == 3'b011) d.shape = op[3] ? SH_DIRRD2 : SH_DIRWR2;
      else d.bad = 1'b1;
    end else if (op == 8'hDD || op == 8'hFD) begin
      d.isPfx = 1'b1; d.nextPfx = PFX_IDX;
    end else if (op == 8'hED) begin
      d.isPfx = 1'b1; d.nextPfx = PFX_EXT;
    end else if (pfx == PFX_IDX) begin
      if (op[7:6] == 2'b01) begin
        if (op == 8'h76)             d.bad = 1'b1;
        else if (op[2:0] == 3'b110)  d.shape = SH_IDXRD;
        else if (op[5:3] == 3'b110)  d.shape = SH_IDXWR;
      end
      else if (op == 8'h36) d.shape = SH_IDXIMM;
      else if (op == 8'h21) d.shape = SH_IMM16;
      else if (op == 8'h22) d.shape = SH_DIRWR2;
      else if (op == 8'h2A) d.shape = SH_DIRRD2;
      else if (op == 8'hF9) d.shape = SH_SPLD;
      else if (op == 8'hE1) d.shape = SH_POP;
      else if (op == 8'hE5) d.shape = SH_PUSH;
      else d.bad = 1'b1;
    end else begin
      if (op[7:6] == 2'b01) begin
        if (op == 8'h76)             d.shape = SH_NONE;
        else if (op[2:0] == 3'b110)  d.shape = SH_RD1;
        else if (op[5:3] == 3'b110)  d.shape = SH_WR1;
      end
      else if (op[7:6] == 2'b00 && op[2:0] == 3'b110) d.shape = (op == 8'h36) ? SH_MEMIMM : SH_IMM8;
      else if (op == 8'h02 || op == 8'h12) d.shape = SH_WR1;
      else if (op == 8'h0A || op == 8'h1A) d.shape = SH_RD1;
      else if (op == 8'h32) d.shape = SH_DIRWR1;
      else if (op == 8'h3A) d.shape = SH_DIRRD1;
      else if (op == 8'h22) d.shape = SH_DIRWR2;
      else if (op == 8'h2A) d.shape = SH_DIRRD2;
      else if (op[7:6] == 2'b00 && op[3:0] == 4'b0001) d.shape = SH_IMM16;
      else if (op == 8'hF9) d.shape = SH_SPLD;
      else if (op[7:6] == 2'b11 && op[3:0] == 4'b0101) d.shape = SH_PUSH;
      else if (op[7:6] == 2'b11 && op[3:0] == 4'b0001) d.shape = SH_POP;
    end
    if (d.shape == SH_SPLD) d.fetchLen = 3'd6;
    else if (d.shape == SH_PUSH) d.fetchLen = 3'd5;
    return d;
  endfunction

endpackage

// File: rtl/ld_seq_ctrl.sv
module ld_seq_ctrl
  import ld_cycle_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [7:0]     opcode,
  output strobe_t        stb,
  output cyc_e           cycType,
  output logic [T_W-1:0] tState,
  output logic           operandCyc,
  output logic           instDone,
  output logic           illegal
);

  logic           inFetch;
  shape_e         shapeQ;
  logic [T_W-1:0] stepQ;
  logic [T_W-1:0] tQ;
  pfx_e           pfxQ;
  logic           illegalQ;

  dec_t           dec;
  step_t          desc;
  logic [T_W-1:0] curLen;
  logic           cycEnd;
  logic           lastCyc;

  always_comb begin
    dec     = decode(pfxQ, opcode);
    desc    = seqStep(shapeQ, stepQ);
    curLen  = inFetch ? dec.fetchLen : desc.len;
    cycEnd  = (tQ == curLen - 3'd1);
    lastCyc = inFetch ? (!dec.isPfx && !hasSteps(dec.shape)) : desc.last;
  end

  assign instDone   = cycEnd && lastCyc;
  assign cycType    = inFetch ? CYC_FETCH : desc.cyc;
  assign operandCyc = !inFetch && desc.opnd;
  assign tState     = tQ;
  assign illegal    = illegalQ;

  always_comb begin
    stb.latchOp   = inFetch && (tQ == 3'd1);
    stb.pcInc     = cycEnd && (inFetch || desc.opnd);
    stb.latchOpnd = cycEnd && !inFetch && desc.opnd;
    stb.spDec2    = cycEnd && inFetch && !dec.isPfx && dec.shape == SH_PUSH;
    stb.spInc2    = instDone && !inFetch && shapeQ == SH_POP;
    stb.addrSel   = inFetch ? AS_PC : desc.addr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFetch  <= 1'b1;
      shapeQ   <= SH_NONE;
      stepQ    <= '0;
      tQ       <= '0;
      pfxQ     <= PFX_NONE;
      illegalQ <= 1'b0;
    end else if (cycEnd) begin
      tQ <= '0;
      if (inFetch) begin
        if (dec.isPfx) begin
          pfxQ <= dec.nextPfx;
        end else begin
          pfxQ   <= PFX_NONE;
          shapeQ <= dec.shape;
          stepQ  <= '0;
          if (dec.bad) illegalQ <= 1'b1;
          inFetch <= !hasSteps(dec.shape);
        end
      end else if (desc.last) begin
        inFetch <= 1'b1;
      end else begin
        stepQ <= stepQ + 3'd1;
      end
    end else begin
      tQ <= tQ + 3'd1;
    end
  end

  // R13
  tstate_range_chk: assert property (@(posedge clk) disable iff (!rstN) tQ < curLen);
  // R13
  tstate_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tQ != 3'd0) |-> (tQ == $past(tQ) + 3'd1));
  // R11
  done_next_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    instDone |=> (cycType == CYC_FETCH && tQ == 3'd0));
  // R10
  operand_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    operandCyc |-> (cycType == CYC_READ));
  // R12
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalQ |=> illegalQ);

endmodule

// File: rtl/ld_seq_dp.sv
module ld_seq_dp
  import ld_cycle_seq_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] PC_INIT = '0,
  parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        memData,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] spVal
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] pcQ, spQ;
  logic [7:0]        opQ, loQ, hiQ;
  logic [ADDR_W-1:0] dirAddr;

  assign dirAddr = ADDR_W'({hiQ, loQ});
  assign opcode  = opQ;
  assign spVal   = spQ;

  always_comb begin
    case (stb.addrSel)
      AS_PTR:   memAddr = '0;
      AS_DIR0:  memAddr = dirAddr;
      AS_DIR1:  memAddr = dirAddr + ONE;
      AS_STKLO: memAddr = spQ;
      AS_STKHI: memAddr = spQ + ONE;
      default:  memAddr = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= PC_INIT;
      spQ <= SP_INIT;
      opQ <= '0;
      loQ <= '0;
      hiQ <= '0;
    end else begin
      if (stb.latchOp)   opQ <= memData;
      if (stb.pcInc)     pcQ <= pcQ + ONE;
      if (stb.latchOpnd) begin
        loQ <= hiQ;
        hiQ <= memData;
      end
      if (stb.spDec2)      spQ <= spQ - TWO;
      else if (stb.spInc2) spQ <= spQ + TWO;
    end
  end

  // R8
  sp_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.spDec2 |=> (spQ == $past(spQ) - TWO));
  // R9
  sp_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.spInc2 |=> (spQ == $past(spQ) + TWO));

endmodule

// File: rtl/ld_cycle_seq.sv
module ld_cycle_seq
  import ld_cycle_seq_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] PC_INIT = '0,
  parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        cycType,
  output logic [T_W-1:0]    tState,
  output logic              operandCyc,
  output logic              instDone,
  output logic              illegal,
  output logic [ADDR_W-1:0] spVal
);

  strobe_t    stb;
  cyc_e       cycE;
  logic [7:0] opcode;

  ld_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .stb(stb), .cycType(cycE),
    .tState(tState), .operandCyc(operandCyc), .instDone(instDone), .illegal(illegal)
  );

  ld_seq_dp #(.ADDR_W(ADDR_W), .PC_INIT(PC_INIT), .SP_INIT(SP_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memData(memData), .opcode(opcode),
    .memAddr(memAddr), .spVal(spVal)
  );

  assign cycType = cycE;

endmodule

// File: tb/ld_cycle_seq_bench.sv
module ld_cycle_seq_bench;

  localparam int          ADDR_W = 16;
  localparam logic [15:0] SP0    = 16'h8000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  mem [256];
  logic [7:0]  memData;
  logic [15:0] memAddr, spVal;
  logic [1:0]  cycType;
  logic [2:0]  tState;
  logic        operandCyc, instDone, illegal;

  int          errs = 0;
  int          checks = 0;
  logic [15:0] pcT = 16'h0000;
  logic [15:0] spT = SP0;
  bit          expIll = 1'b0;

  always #10 clk = ~clk;

  assign memData = mem[memAddr[7:0]];

  ld_cycle_seq #(.ADDR_W(ADDR_W), .PC_INIT(16'h0000), .SP_INIT(SP0)) u_ld_cycle_seq (
    .clk(clk), .rstN(rstN), .memData(memData), .memAddr(memAddr), .cycType(cycType),
    .tState(tState), .operandCyc(operandCyc), .instDone(instDone), .illegal(illegal),
    .spVal(spVal)
  );

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %s expected %s", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // Run one instruction from the current fetch T0 and check its cycle signature.
  task automatic run(input int n, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input logic [7:0] b3, input string expSig,
                     input int nAddr, input logic [15:0] ea0, input logic [15:0] ea1,
                     input int spDelta, input string req);
    string       sig = "";
    string       letter = "";
    int          len = 0;
    int          guard = 0;
    int          na = 0;
    bit          done = 1'b0;
    logic [15:0] ga [4];
    logic [7:0]  bb [4];
    bb = '{b0, b1, b2, b3};
    for (int i = 0; i < 4; i++) ga[i] = 16'hxxxx;
    for (int i = 0; i < n; i++) mem[pcT[7:0] + 8'(i)] = bb[i];
    while (!done && guard < 60) begin
      if (tState == 3'd0) begin
        if (len > 0) sig = {sig, $sformatf("%s%0d", letter, len)};
        case (cycType)
          2'b00:   letter = "F";
          2'b01:   letter = operandCyc ? "N" : "R";
          2'b10:   letter = "W";
          default: letter = "I";
        endcase
        if (operandCyc && cycType != 2'b01) letter = "X";
        len = 1;
        if (!operandCyc && (cycType == 2'b01 || cycType == 2'b10)) begin
          if (na < 4) ga[na] = memAddr;
          na++;
        end
      end else begin
        len++;
      end
      if (instDone) begin
        sig  = {sig, $sformatf("%s%0d", letter, len)};
        done = 1'b1;
      end
      @(negedge clk);
      guard++;
    end
    chk(done, {req, " R11"}, "no done pulse", "done pulse");
    chk(sig == expSig, {req, " R13"}, sig, expSig);
    chk(na == nAddr, req, $sformatf("%0d data accesses", na), $sformatf("%0d", nAddr));
    if (nAddr >= 1)
      chk(ga[0] === ea0, req, $sformatf("addr0 %h", ga[0]), $sformatf("%h", ea0));
    if (nAddr >= 2)
      chk(ga[1] === ea1, req, $sformatf("addr1 %h", ga[1]), $sformatf("%h", ea1));
    pcT = pcT + 16'(n);
    spT = spT + 16'(spDelta);
    chk(cycType == 2'b00 && tState == 3'd0 && memAddr == pcT, "R11",
        $sformatf("type %0d t %0d addr %h", cycType, tState, memAddr),
        $sformatf("type 0 t 0 addr %h", pcT));
    chk(spVal == spT, req, $sformatf("sp %h", spVal), $sformatf("%h", spT));
    chk(illegal == expIll, "R12", $sformatf("illegal %0b", illegal), $sformatf("%0b", expIll));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cycType == 2'b00 && tState == 3'd0, "R1",
        $sformatf("type %0d t %0d", cycType, tState), "type 0 t 0");
    chk(memAddr == 16'h0000 && spVal == SP0, "R1",
        $sformatf("addr %h sp %h", memAddr, spVal), $sformatf("addr 0000 sp %h", SP0));
    chk(!instDone && !illegal, "R1",
        $sformatf("done %0b ill %0b", instDone, illegal), "done 0 ill 0");
    rstN = 1'b1;

    // R2 / R3 sweep of every 01dddsss code
    for (int op = 8'h40; op <= 8'h7F; op++) begin
      logic [7:0] o;
      o = 8'(op);
      if (o == 8'h76)              run(1, o, 0, 0, 0, "F4", 0, 0, 0, 0, "R2");
      else if (o[2:0] == 3'b110)   run(1, o, 0, 0, 0, "F4R3", 1, 16'h0, 0, 0, "R3");
      else if (o[5:3] == 3'b110)   run(1, o, 0, 0, 0, "F4W3", 1, 16'h0, 0, 0, "R3");
      else                         run(1, o, 0, 0, 0, "F4", 0, 0, 0, 0, "R2");
    end
    run(1, 8'h87, 0, 0, 0, "F4", 0, 0, 0, 0, "R2");
    run(2, 8'hDD, 8'h7C, 0, 0, "F4F4", 0, 0, 0, 0, "R2");

    // R3 pointer and immediate forms, R10 operand marking
    run(2, 8'h06, 8'h5A, 0, 0, "F4N3", 0, 0, 0, 0, "R10");
    run(2, 8'h36, 8'h77, 0, 0, "F4N3W3", 1, 16'h0, 0, 0, "R3");
    run(1, 8'h02, 0, 0, 0, "F4W3", 1, 16'h0, 0, 0, "R3");
    run(1, 8'h0A, 0, 0, 0, "F4R3", 1, 16'h0, 0, 0, "R3");
    run(1, 8'h12, 0, 0, 0, "F4W3", 1, 16'h0, 0, 0, "R3");
    run(1, 8'h1A, 0, 0, 0, "F4R3", 1, 16'h0, 0, 0, "R3");

    // R4 indexed forms and chained prefixes
    run(3, 8'hDD, 8'h46, 8'h05, 0, "F4F4N3I5R3", 1, 16'h0, 0, 0, "R4");
    run(3, 8'hFD, 8'h70, 8'hF0, 0, "F4F4N3I5W3", 1, 16'h0, 0, 0, "R4");
    run(4, 8'hDD, 8'h36, 8'h02, 8'h99, "F4F4N3N3I2W3", 1, 16'h0, 0, 0, "R4");
    run(4, 8'hFD, 8'hDD, 8'h7E, 8'h01, "F4F4F4N3I5R3", 1, 16'h0, 0, 0, "R4");

    // R5 direct accumulator access
    run(3, 8'h32, 8'h34, 8'h12, 0, "F4N3N3W3", 1, 16'h1234, 0, 0, "R5");
    run(3, 8'h3A, 8'hCD, 8'hAB, 0, "F4N3N3R3", 1, 16'hABCD, 0, 0, "R5");

    // R6 16-bit forms
    run(3, 8'h01, 8'h11, 8'h22, 0, "F4N3N3", 0, 0, 0, 0, "R6");
    run(3, 8'h31, 8'h11, 8'h22, 0, "F4N3N3", 0, 0, 0, 0, "R6");
    run(4, 8'hDD, 8'h21, 8'h11, 8'h22, "F4F4N3N3", 0, 0, 0, 0, "R6");
    run(3, 8'h22, 8'h78, 8'h56, 0, "F4N3N3W3W3", 2, 16'h5678, 16'h5679, 0, "R6");
    run(3, 8'h2A, 8'hFF, 8'h10, 0, "F4N3N3R3R3", 2, 16'h10FF, 16'h1100, 0, "R6");
    run(4, 8'hDD, 8'h22, 8'h00, 8'h40, "F4F4N3N3W3W3", 2, 16'h4000, 16'h4001, 0, "R6");
    run(4, 8'hFD, 8'h2A, 8'h10, 8'h20, "F4F4N3N3R3R3", 2, 16'h2010, 16'h2011, 0, "R6");
    run(4, 8'hED, 8'h43, 8'h02, 8'h30, "F4F4N3N3W3W3", 2, 16'h3002, 16'h3003, 0, "R6");
    run(4, 8'hED, 8'h7B, 8'h08, 8'h30, "F4F4N3N3R3R3", 2, 16'h3008, 16'h3009, 0, "R6");

    // R7 stack-pointer load
    run(1, 8'hF9, 0, 0, 0, "F6", 0, 0, 0, 0, "R7");
    run(2, 8'hFD, 8'hF9, 0, 0, "F4F6", 0, 0, 0, 0, "R7");

    // R8 push and R9 pop over all pairs
    for (int p = 0; p < 4; p++) begin
      run(1, 8'hC5 | 8'(p << 4), 0, 0, 0, "F5W3W3", 2, spT - 16'd1, spT - 16'd2, -2, "R8");
    end
    run(2, 8'hDD, 8'hE5, 0, 0, "F4F5W3W3", 2, spT - 16'd1, spT - 16'd2, -2, "R8");
    for (int p = 0; p < 4; p++) begin
      run(1, 8'hC1 | 8'(p << 4), 0, 0, 0, "F4R3R3", 2, spT, spT + 16'd1, 2, "R9");
    end
    run(2, 8'hFD, 8'hE1, 0, 0, "F4F4R3R3", 2, spT, spT + 16'd1, 2, "R9");

    // R12 unknown prefixed opcodes and stickiness
    expIll = 1'b1;
    run(2, 8'hDD, 8'h01, 0, 0, "F4F4", 0, 0, 0, 0, "R12");
    run(1, 8'h00, 0, 0, 0, "F4", 0, 0, 0, 0, "R12");
    run(2, 8'hED, 8'h00, 0, 0, "F4F4", 0, 0, 0, 0, "R12");
    run(3, 8'h3A, 8'h00, 8'h50, 0, "F4N3N3R3", 1, 16'h5000, 0, 0, "R12");

    summary();
    $finish;
  end

endmodule